// File: doc/BRIEF.md
# Memory Bus Port with Run-State Control

This block connects a simple load/store processor core to an external byte-wide memory. The core presents one request at a time (an instruction fetch, a load or a store, with a size of one, two or four bytes), and the block turns it into a series of single-byte bus cycles. It drives the address, the read/write select and the enable strobe, and it owns a bidirectional data bus. Each byte cycle holds the enable strobe until memory answers on its ready line. Read bytes are assembled with the lowest address as the most significant byte. When the last byte completes, the core gets a one-cycle completion pulse.

The block also holds the run state of the processor. The halt input is looked at only when a fetch is about to start. While halted, the block releases every bus line to high impedance and waits until halt falls, then runs the same fetch. A misaligned address, a reserved size code or a reserved request kind sends the block into a fault state. In that state it raises the error output, releases the bus and stays there until the asynchronous reset is applied. The core holds its request fields stable from raising `req_valid` until it sees `req_done`, and drops or replaces the request in the cycle after that.

The states are ST_IDLE, ST_HALT, ST_XFER, ST_DONE and ST_ERR. The transitions are:
- ST_IDLE to ST_HALT on a fetch request while halt is high.
- ST_IDLE to ST_ERR on a faulty request.
- ST_IDLE to ST_XFER on any other request.
- ST_HALT to ST_IDLE when halt is low.
- ST_XFER to ST_DONE when ready is sampled on the last byte.
- ST_DONE to ST_IDLE unconditionally.
- ST_ERR to itself until reset.

Top module: `cpu_mem_port`

## Requirements
- R1: While reset is high and after it is released, the enable and read/write outputs are 0, error is 0, the done pulse is 0 and the data bus is not driven.
- R2: A byte cycle drives enable high with read/write at 1 for a read and 0 for a write. Enable and the address are held until ready is sampled high. A request whose bytes each wait L extra cycles for ready completes with done seen n*(L+2) cycles after the request is raised, where n is the byte count.
- R3: Request kind codes are 0 fetch, 1 load, 2 store and 3 reserved. Size codes are 0 byte, 1 half (2 bytes), 2 word (4 bytes) and 3 reserved. A request becomes n single-byte bus cycles at addresses base, base+1, and so on up to base+n-1, in that order. A fetch always moves 4 bytes, whatever the size code.
- R4: Read data is returned in `req_rdata` right-aligned and zero-extended, with the byte from the lowest address most significant. A store writes the n low bytes of `req_wdata`, most significant of those first, to ascending addresses.
- R5: `req_done` is high for exactly one cycle, the cycle after ready is sampled on the last byte, and `req_rdata` is valid in that cycle.
- R6: The data bus is driven by the block only while enable is high during a write. It is released at all other times.
- R7: Halt is sampled only when a fetch is about to start. If halt is high, no bus cycle occurs and the address, enable, read/write and data lines are all at high impedance until halt is low; then the same fetch runs. Halt has no effect on loads and stores.
- R8: A half request with address bit 0 set, a word or fetch request with address bits [1:0] not zero, size code 3, or kind code 3 raises error in the cycle after the request is seen, with no bus cycle.
- R9: Once error is high it stays high until reset. No done pulse or bus cycle occurs, and the address, enable, read/write and data lines are at high impedance.
- R10: When a fetch request is both misaligned and met by a high halt, the halt wins. The block idles halted without error, and error rises two cycles after halt falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| halt_i | input | 1 | Halt request, checked before each fetch |
| req_valid | input | 1 | Core request present |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| req_addr | input | 8 | Base byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Assembled read data, right-aligned |
| mem_addr | output | 8 | Memory address, tri-stated when halted or in error |
| mem_data | inout | 8 | Bidirectional data bus |
| mem_rw | output | 1 | 1 read, 0 write; tri-stated when halted or in error |
| mem_enable | output | 1 | Bus cycle strobe; tri-stated when halted or in error |
| mem_ready | input | 1 | Memory completion for the current byte |
| error_o | output | 1 | Unrecoverable fault indicator |

## Verification
The halt check and the alignment check both act on the same pending fetch in ST_IDLE. The bench provokes the overlap by raising halt and presenting a fetch at an address with bit 0 or bit 1 set in the same cycle. It then judges the outcome from the port behaviour. The bus lines must read back a pattern that the bench drives onto them, and error must stay low for several cycles. After halt falls, error must rise exactly two cycles later with no byte cycle logged. The same pairing with an aligned fetch is checked to confirm that the fetch completes after release.

// File: rtl/memport_pkg.sv
package memport_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALT,
        ST_XFER,
        ST_DONE,
        ST_ERR
    } port_state_e;

endpackage

// File: rtl/memport_align.sv
module memport_align
    import memport_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic [1:0]        kind,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output logic              fault,
    output logic [CNT_W-1:0]  nbytes
);

    localparam int HALF_BYTES = MAX_BYTES / 2;

    kind_e             k;
    size_e             s;
    logic              code_bad;
    logic [ADDR_W-1:0] mask;

    assign k = kind_e'(kind);
    assign s = size_e'(size);

    always_comb begin
        code_bad = 1'b0;
        nbytes   = CNT_W'(1);
        if (k == KIND_FETCH) begin
            nbytes = CNT_W'(MAX_BYTES);
        end else begin
            unique case (s)
                SZ_BYTE: nbytes = CNT_W'(1);
                SZ_HALF: nbytes = CNT_W'(HALF_BYTES);
                SZ_WORD: nbytes = CNT_W'(MAX_BYTES);
                SZ_RSVD: code_bad = 1'b1;
            endcase
        end
        if (k == KIND_RSVD) begin
            code_bad = 1'b1;
        end
    end

    // the low address bits must be clear below the access size
    assign mask  = ADDR_W'(nbytes) - ADDR_W'(1);
    assign fault = code_bad || ((addr & mask) != '0);

endmodule

// File: rtl/memport_shift.sv
module memport_shift #(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [MAX_BYTES*BYTE_W-1:0] load_val,
    input  logic [CNT_W-1:0]            nbytes,
    input  logic                        step,
    input  logic [BYTE_W-1:0]           in_byte,
    output logic [BYTE_W-1:0]           out_byte,
    output logic [MAX_BYTES*BYTE_W-1:0] next_word
);

    localparam int W = MAX_BYTES * BYTE_W;

    logic [W-1:0] sh;

    // big-endian: the oldest byte moves toward the top as new ones enter
    assign next_word = {sh[W-BYTE_W-1:0], in_byte};
    assign out_byte  = sh[W-1 -: BYTE_W];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= load_val << (BYTE_W * (MAX_BYTES - int'(nbytes)));
        end else if (step) begin
            sh <= next_word;
        end
    end

endmodule

// File: rtl/cpu_mem_port.sv
module cpu_mem_port
    import memport_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        halt_i,
    input  logic                        req_valid,
    input  logic [1:0]                  req_kind,
    input  logic [1:0]                  req_size,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [MAX_BYTES*BYTE_W-1:0] req_wdata,
    output logic                        req_done,
    output logic [MAX_BYTES*BYTE_W-1:0] req_rdata,
    output logic [ADDR_W-1:0]           mem_addr,
    inout  wire  [BYTE_W-1:0]           mem_data,
    output logic                        mem_rw,
    output logic                        mem_enable,
    input  logic                        mem_ready,
    output logic                        error_o
);

    localparam int W     = MAX_BYTES * BYTE_W;
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    port_state_e       state, state_nx;
    logic              fault;
    logic [CNT_W-1:0]  req_n;
    logic [CNT_W-1:0]  n_q;
    logic [CNT_W-1:0]  idx;
    logic [ADDR_W-1:0] base_q;
    logic              rd_q;
    logic              start;
    logic              last_byte;
    logic              byte_ok;
    logic              fetch_req;
    logic              bus_own;
    logic              en_int;
    logic              rw_int;
    logic              drive_data;
    logic [ADDR_W-1:0] addr_int;
    logic [BYTE_W-1:0] wr_byte;
    logic [W-1:0]      next_word;
    logic [W-1:0]      load_val;

    memport_align #(
        .ADDR_W   (ADDR_W),
        .MAX_BYTES(MAX_BYTES),
        .CNT_W    (CNT_W)
    ) u_align (
        .kind  (req_kind),
        .size  (req_size),
        .addr  (req_addr),
        .fault (fault),
        .nbytes(req_n)
    );

    assign load_val = (kind_e'(req_kind) == KIND_STORE) ? req_wdata : '0;

    memport_shift #(
        .BYTE_W   (BYTE_W),
        .MAX_BYTES(MAX_BYTES),
        .CNT_W    (CNT_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (load_val),
        .nbytes   (req_n),
        .step     (byte_ok),
        .in_byte  (mem_data),
        .out_byte (wr_byte),
        .next_word(next_word)
    );

    assign fetch_req = kind_e'(req_kind) == KIND_FETCH;
    assign byte_ok   = (state == ST_XFER) && mem_ready;
    assign last_byte = idx == (n_q - CNT_W'(1));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (fetch_req && halt_i) begin
                        state_nx = ST_HALT;
                    end else if (fault) begin
                        state_nx = ST_ERR;
                    end else begin
                        state_nx = ST_XFER;
                    end
                end
            end
            ST_HALT: if (!halt_i) state_nx = ST_IDLE;
            ST_XFER: if (byte_ok && last_byte) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            ST_ERR:  state_nx = ST_ERR;
            default: state_nx = ST_ERR;
        endcase
    end

    assign start = (state == ST_IDLE) && (state_nx == ST_XFER);

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // request capture and byte counter
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            n_q       <= '0;
            idx       <= '0;
            base_q    <= '0;
            rd_q      <= 1'b0;
            req_rdata <= '0;
        end else if (start) begin
            n_q    <= req_n;
            idx    <= '0;
            base_q <= req_addr;
            rd_q   <= kind_e'(req_kind) != KIND_STORE;
        end else if (byte_ok) begin
            idx <= idx + CNT_W'(1);
            if (last_byte && rd_q) begin
                req_rdata <= next_word;
            end
        end
    end

    // output decode
    always_comb begin
        bus_own    = 1'b0;
        en_int     = 1'b0;
        rw_int     = 1'b0;
        drive_data = 1'b0;
        addr_int   = '0;
        req_done   = 1'b0;
        error_o    = 1'b0;
        unique case (state)
            ST_IDLE: bus_own = 1'b1;
            ST_HALT: bus_own = 1'b0;
            ST_XFER: begin
                bus_own    = 1'b1;
                en_int     = 1'b1;
                rw_int     = rd_q;
                drive_data = !rd_q;
                addr_int   = base_q + ADDR_W'(idx);
            end
            ST_DONE: begin
                bus_own  = 1'b1;
                req_done = 1'b1;
            end
            ST_ERR:  error_o = 1'b1;
            default: error_o = 1'b1;
        endcase
    end

    assign mem_addr   = bus_own ? addr_int : 'z;
    assign mem_enable = bus_own ? en_int   : 1'bz;
    assign mem_rw     = bus_own ? rw_int   : 1'bz;
    assign mem_data   = drive_data ? wr_byte : 'z;

    // R2
    hold_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (en_int && !mem_ready) |=> (en_int && $stable(addr_int)));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    // R8
    fault_to_error_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_valid && !(fetch_req && halt_i) && fault) |=> error_o);

    // R9
    error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        error_o |=> (error_o && !req_done && !en_int));

    // R6
    data_drive_chk: assert property (@(posedge clk) disable iff (rst)
        drive_data |-> (bus_own && en_int && !rw_int));

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && halt_i) |=> (state == ST_HALT && !en_int && !bus_own));

endmodule

// File: tb/sim_cpu_mem_port.sv
module sim_cpu_mem_port;

    logic        clk = 1'b0;
    logic        rst;
    logic        halt;
    logic        valid;
    logic [1:0]  kind;
    logic [1:0]  size;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        done;
    logic [31:0] rdata;
    logic        err;
    logic        rdy;
    logic        probe_all;
    logic        probe_d;
    wire  [7:0]  abus;
    wire  [7:0]  dbus;
    wire         en_w;
    wire         rw_w;

    logic [7:0]  mem [256];
    logic [7:0]  logq [4096];
    int          lat;
    int          cnt;
    int          nlog;
    int          checks;
    int          fails;

    always #5 clk = ~clk;

    cpu_mem_port u0 (
        .clk       (clk),
        .rst       (rst),
        .halt_i    (halt),
        .req_valid (valid),
        .req_kind  (kind),
        .req_size  (size),
        .req_addr  (addr),
        .req_wdata (wdata),
        .req_done  (done),
        .req_rdata (rdata),
        .mem_addr  (abus),
        .mem_data  (dbus),
        .mem_rw    (rw_w),
        .mem_enable(en_w),
        .mem_ready (rdy),
        .error_o   (err)
    );

    // bench-side drivers: probe patterns and the memory read path
    logic rd_oe;
    assign rd_oe = !probe_all && !probe_d && (en_w === 1'b1) && (rw_w === 1'b1);
    assign abus  = probe_all ? 8'h5A : 8'bz;
    assign en_w  = probe_all ? 1'b1 : 1'bz;
    assign rw_w  = probe_all ? 1'b1 : 1'bz;
    assign dbus  = (probe_all || probe_d) ? 8'hC3 : (rd_oe ? mem[abus] : 8'bz);

    // memory responder
    always @(negedge clk) begin
        if (!probe_all && en_w === 1'b1) begin
            if (rdy) begin
                rdy <= 1'b0;
                cnt <= 0;
            end else if (cnt >= lat) begin
                rdy <= 1'b1;
                if (rw_w === 1'b0) mem[abus] <= dbus;
                logq[nlog] <= abus;
                nlog <= nlog + 1;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            rdy <= 1'b0;
            cnt <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        valid = 1'b0;
        halt  = 1'b0;
        repeat (2) @(negedge clk);
        chk(en_w == 1'b0, "R1", "enable in reset", longint'(en_w), 0);
        chk(rw_w == 1'b0, "R1", "rw in reset", longint'(rw_w), 0);
        chk(err == 1'b0, "R1", "error in reset", longint'(err), 0);
        chk(done == 1'b0, "R1", "done in reset", longint'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        probe_d = 1'b1;
        #1;
        chk(dbus == 8'hC3, "R1", "data bus released after reset", longint'(dbus), 8'hC3);
        probe_d = 1'b0;
    endtask

    function automatic int nbytes_of(input logic [1:0] k, input logic [1:0] sz);
        if (k == 2'd0) return 4;
        return (sz == 2'd0) ? 1 : ((sz == 2'd1) ? 2 : 4);
    endfunction

    task automatic run_ok(input logic [1:0] k, input logic [1:0] sz,
                          input logic [7:0] a, input int l, input int extra);
        int n;
        int st;
        int waited;
        logic [31:0] wd;
        logic [31:0] exp;
        n   = nbytes_of(k, sz);
        wd  = {a, ~a, a ^ 8'h5A, a + 8'd1};
        exp = '0;
        for (int i = 0; i < n; i++) exp = (exp << 8) | 32'(mem[a + 8'(i)]);
        lat = l;
        st  = nlog;
        @(negedge clk);
        kind = k; size = sz; addr = a; wdata = wd; valid = 1'b1;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!done && !err && waited < 300);
        valid = 1'b0;
        chk(done == 1'b1, "R5", "done seen", longint'(done), 1);
        chk(waited == n * (l + 2) + extra, "R2", "cycles to done", waited, n * (l + 2) + extra);
        if (k != 2'd2) begin
            chk(rdata == exp, "R4", "assembled read data", rdata, exp);
        end else begin
            for (int i = 0; i < n; i++)
                chk(mem[a + 8'(i)] == wd[8*(n-1-i) +: 8], "R4", "stored byte",
                    mem[a + 8'(i)], wd[8*(n-1-i) +: 8]);
        end
        chk(nlog - st == n, "R3", "byte cycle count", nlog - st, n);
        for (int i = 0; i < n; i++)
            chk(logq[st + i] == a + 8'(i), "R3", "byte address order", logq[st + i], a + 8'(i));
        @(negedge clk);
        chk(done == 1'b0, "R5", "done is a single pulse", longint'(done), 0);
    endtask

    task automatic probe_released(input string req);
        probe_all = 1'b1;
        #1;
        chk(abus == 8'h5A, req, "address released", abus, 8'h5A);
        chk(en_w == 1'b1, req, "enable released", longint'(en_w), 1);
        chk(rw_w == 1'b1, req, "rw released", longint'(rw_w), 1);
        chk(dbus == 8'hC3, req, "data released", dbus, 8'hC3);
        probe_all = 1'b0;
        #1;
    endtask

    task automatic run_fault(input logic [1:0] k, input logic [1:0] sz, input logic [7:0] a);
        int st;
        st = nlog;
        @(negedge clk);
        kind = k; size = sz; addr = a; valid = 1'b1;
        @(negedge clk);
        chk(err == 1'b1, "R8", "error one cycle after bad request", longint'(err), 1);
        valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(err == 1'b1 && done == 1'b0, "R9", "error held, no done", longint'(err), 1);
        probe_released("R9");
        kind = 2'd1; size = 2'd0; addr = 8'd4; valid = 1'b1;
        repeat (4) @(negedge clk);
        valid = 1'b0;
        chk(nlog == st, "R8", "no bus cycle on fault", nlog - st, 0);
        do_reset();
        chk(err == 1'b0, "R9", "reset clears error", longint'(err), 0);
    endtask

    task automatic main_seq();
        int st;
        int waited;
        logic [31:0] exp;
        do_reset();

        // R3 R4 R2: sweep kinds, sizes, aligned addresses, latencies
        for (int l = 0; l < 3; l++) begin
            for (int a = 0; a < 32; a += 4)
                run_ok(2'd0, 2'(l), 8'(a), l, 0);
            for (int k = 1; k < 3; k++)
                for (int s = 0; s < 3; s++)
                    for (int a = 0; a < 32; a++)
                        if ((a % nbytes_of(2'(k), 2'(s))) == 0)
                            run_ok(2'(k), 2'(s), 8'(a + 40 * k), l, 0);
        end

        // R6: data bus idle between requests
        probe_d = 1'b1;
        #1;
        chk(dbus == 8'hC3, "R6", "data bus released while idle", dbus, 8'hC3);
        probe_d = 1'b0;

        // R7: halted fetch, then resume
        halt = 1'b1;
        lat  = 0;
        st   = nlog;
        exp  = {mem[8], mem[9], mem[10], mem[11]};
        @(negedge clk);
        kind = 2'd0; size = 2'd2; addr = 8'd8; valid = 1'b1;
        repeat (6) @(negedge clk);
        chk(done == 1'b0 && err == 1'b0, "R7", "halted fetch stalls", longint'(done), 0);
        chk(nlog == st, "R7", "no bus cycle while halted", nlog - st, 0);
        probe_released("R7");
        halt   = 1'b0;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!done && waited < 100);
        valid = 1'b0;
        chk(waited == 9, "R7", "resume timing", waited, 9);
        chk(rdata == exp, "R7", "resumed fetch data", rdata, exp);
        @(negedge clk);

        // R7: halt ignored for load and store
        halt = 1'b1;
        run_ok(2'd1, 2'd2, 8'd16, 0, 0);
        run_ok(2'd2, 2'd1, 8'd22, 1, 0);
        halt = 1'b0;

        // R8 R9: faults
        for (int a = 0; a < 8; a++) begin
            if (a[0]) run_fault(2'd1, 2'd1, 8'(a));
            if (a[1:0] != 2'b00) begin
                run_fault(2'd2, 2'd2, 8'(a));
                run_fault(2'd0, 2'd0, 8'(a));
            end
        end
        run_fault(2'd1, 2'd3, 8'd0);
        run_fault(2'd3, 2'd0, 8'd0);

        // R10: halt and misalignment on the same fetch
        for (int a = 1; a < 4; a++) begin
            halt = 1'b1;
            st   = nlog;
            @(negedge clk);
            kind = 2'd0; size = 2'd2; addr = 8'(a); valid = 1'b1;
            repeat (5) @(negedge clk);
            chk(err == 1'b0, "R10", "halt wins over fault", longint'(err), 0);
            probe_released("R10");
            halt = 1'b0;
            @(negedge clk);
            chk(err == 1'b0, "R10", "no error one cycle after release", longint'(err), 0);
            @(negedge clk);
            chk(err == 1'b1, "R10", "error two cycles after release", longint'(err), 1);
            chk(nlog == st, "R10", "no byte cycle", nlog - st, 0);
            valid = 1'b0;
            do_reset();
        end
    endtask

    initial begin
        checks    = 0;
        fails     = 0;
        nlog      = 0;
        cnt       = 0;
        lat       = 0;
        rdy       = 1'b0;
        probe_all = 1'b0;
        probe_d   = 1'b0;
        rst       = 1'b1;
        halt      = 1'b0;
        valid     = 1'b0;
        kind      = '0;
        size      = '0;
        addr      = '0;
        wdata     = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule